// File: doc/BRIEF.md
# Flagged Real-Time Serial Monitor

This block sends a frame of four 32-bit monitor words out of the chip on one data line. A second line carries a test clock so that an external receiver can capture each bit. A compute engine pulses `start_i` when one of its opcodes marks the end of an accumulation interval. The block then takes a copy of the four words and sends each one as a single flag bit followed by the 32 data bits, least significant bit first. After the last word it holds the line low for a few idle cycles. The frame length is fixed at 140 fast-clock cycles, so the transfer always ends before the next compute pass begins.

The control is a four-state machine:

- `ST_IDLE` waits for a start strobe.
- `ST_FLAG` sends one flag bit. The flag is high only in front of word 0, so a receiver can find word 0.
- `ST_DATA` shifts out the 32 bits of the current word.
- `ST_PAD` holds the line low for the idle tail.

The transitions are:

- IDLE→FLAG on start.
- FLAG→DATA always.
- DATA→FLAG after bit 31 of words 0 to 2.
- DATA→PAD after bit 31 of the last word.
- PAD→IDLE after the last pad cycle.

Data changes on the rising fast-clock edge. The test clock is the inverted fast clock, gated so that it runs only while bits are being sent. Its rising edge therefore falls in the middle of each bit.

Top module: `flag_word_serializer`

## Requirements
- R1: While reset is held and while idle, `busy_o`, `sdata_o` and `sclk_o` are low. A start strobe seen during reset has no effect.
- R2: A start strobe sampled while idle sets `busy_o` at the next clock edge. `busy_o` then stays high for exactly 140 cycles.
- R3: The flag bit is sent in frame cycles 0, 33, 66 and 99. Its value is 1 before word 0 and 0 before words 1, 2 and 3.
- R4: Word w is taken from `words_i[32*w+31:32*w]`. Its bit k is on `sdata_o` in frame cycle 33*w+1+k, for k from 0 to 31.
- R5: In frame cycles 132 to 139, `sdata_o` is low and `sclk_o` does not pulse.
- R6: In each bit cycle (0 to 131), `sclk_o` is low while the fast clock is high and high while it is low. `sdata_o` stays stable across that rising edge.
- R7: A start strobe while `busy_o` is high, including in the last frame cycle, is ignored. The frame and its length do not change.
- R8: The words are captured when the start strobe is accepted. Changes on `words_i` during a frame do not alter the bits sent.
- R9: After a frame, `busy_o` is low for at least one cycle. If start is held high, a new frame begins in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Transmission request strobe from the engine |
| words_i | input | 128 | Four monitor words, word w at bits 32*w+31:32*w |
| sdata_o | output | 1 | Serial data line |
| sclk_o | output | 1 | Gated test clock for the receiver |
| busy_o | output | 1 | High for the full 140-cycle frame |

## Verification
The bench uses the default parameters: 32-bit words, four words and eight pad cycles. These give the full 140-cycle frame, every flag position, the word boundaries at cycles 32/33, 65/66 and 98/99, and the change from the last data bit to the pad. The bench drives a start strobe mid-frame and in the very last pad cycle, changes the words after capture, and holds start high across frames. These exercise the ignore rule, the snapshot and the minimum idle gap.

// File: rtl/fws_pkg.sv
package fws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FLAG = 2'd1,
        ST_DATA = 2'd2,
        ST_PAD  = 2'd3
    } fws_state_t;

    function automatic int fws_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fws_sequencer.sv
module fws_sequencer
    import fws_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int NUM_WORDS  = 4,
    parameter int PAD_CYCLES = 8
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          start_i,
    output logic                                          busy_o,
    output logic                                          capture_o,
    output logic                                          load_o,
    output logic                                          shift_o,
    output logic                                          in_flag_o,
    output logic                                          first_word_o,
    output logic                                          bit_window_o,
    output logic [((NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1)-1:0] word_idx_o
);

    localparam int WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int MAXC   = fws_max(WORD_W, PAD_CYCLES);
    localparam int CNT_W  = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0]  LAST_PAD  = CNT_W'(PAD_CYCLES - 1);
    localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(NUM_WORDS - 1);

    fws_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [WIDX_W-1:0] widx_q;
    logic              word_done;
    logic              pad_done;

    assign word_done = (cnt_q == LAST_BIT);
    assign pad_done  = (cnt_q == LAST_PAD);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_FLAG;
            ST_FLAG: state_d = ST_DATA;
            ST_DATA: begin
                if (word_done) begin
                    state_d = (widx_q == LAST_WORD) ? ST_PAD : ST_FLAG;
                end
            end
            ST_PAD:  if (pad_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Bit and word counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            widx_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q  <= '0;
                    widx_q <= '0;
                end
                ST_FLAG: cnt_q <= '0;
                ST_DATA: begin
                    if (word_done) begin
                        cnt_q  <= '0;
                        widx_q <= widx_q + WIDX_W'(1);
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_PAD:  cnt_q <= cnt_q + CNT_W'(1);
                default: cnt_q <= '0;
            endcase
        end
    end

    // Output decode
    always_comb begin
        busy_o       = 1'b1;
        capture_o    = 1'b0;
        load_o       = 1'b0;
        shift_o      = 1'b0;
        in_flag_o    = 1'b0;
        bit_window_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o    = 1'b0;
                capture_o = start_i;
            end
            ST_FLAG: begin
                load_o       = 1'b1;
                in_flag_o    = 1'b1;
                bit_window_o = 1'b1;
            end
            ST_DATA: begin
                shift_o      = 1'b1;
                bit_window_o = 1'b1;
            end
            ST_PAD:  ;
            default: busy_o = 1'b0;
        endcase
    end

    assign first_word_o = (widx_q == '0);
    assign word_idx_o   = widx_q;

    assert_flag_then_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLAG) |=> (state_q == ST_DATA));

    assert_idle_on_pad_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAD && pad_done) |=> (state_q == ST_IDLE));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && state_q != ST_PAD) |=> busy_o);

endmodule

// File: rtl/fws_shifter.sv
module fws_shifter #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          capture_i,
    input  logic                                          load_i,
    input  logic                                          shift_i,
    input  logic [((NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1)-1:0] word_idx_i,
    input  logic [NUM_WORDS*WORD_W-1:0]                   words_i,
    output logic                                          bit_o
);

    localparam int TOTAL_W = NUM_WORDS * WORD_W;

    logic [TOTAL_W-1:0] snap_q;
    logic [WORD_W-1:0]  shreg_q;
    logic [WORD_W-1:0]  selected;

    // Snapshot storage, one slice per monitored word
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_snap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                snap_q[g*WORD_W +: WORD_W] <= '0;
            end else if (capture_i) begin
                snap_q[g*WORD_W +: WORD_W] <= words_i[g*WORD_W +: WORD_W];
            end
        end
    end

    always_comb begin
        selected = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_idx_i == ($bits(word_idx_i))'(w)) begin
                selected = snap_q[w*WORD_W +: WORD_W];
            end
        end
    end

    // Right shift: bit 0 leaves first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (load_i) begin
            shreg_q <= selected;
        end else if (shift_i) begin
            shreg_q <= {1'b0, shreg_q[WORD_W-1:1]};
        end
    end

    assign bit_o = shreg_q[0];

    assert_snapshot_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_i) |=> $stable(snap_q));

endmodule

// File: rtl/fws_strobe.sv
module fws_strobe (
    input  logic clk,
    input  logic window_i,
    output logic sclk_o
);

    // The window changes just after the rising fast edge, while the
    // inverted clock is already low, so the gated strobe has no runt pulse.
    assign sclk_o = ~clk & window_i;

endmodule

// File: rtl/flag_word_serializer.sv
module flag_word_serializer
    import fws_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int NUM_WORDS  = 4,
    parameter int PAD_CYCLES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [NUM_WORDS*WORD_W-1:0] words_i,
    output logic                        sdata_o,
    output logic                        sclk_o,
    output logic                        busy_o
);

    localparam int WIDX_W  = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int NBITS   = NUM_WORDS * (WORD_W + 1);
    localparam int FRAME   = NBITS + PAD_CYCLES;
    localparam int FLEN_W  = $clog2(FRAME + 1);

    logic              capture, load, shift, in_flag, first_word, window;
    logic              shift_bit;
    logic [WIDX_W-1:0] word_idx;

    fws_sequencer #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .PAD_CYCLES(PAD_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .busy_o      (busy_o),
        .capture_o   (capture),
        .load_o      (load),
        .shift_o     (shift),
        .in_flag_o   (in_flag),
        .first_word_o(first_word),
        .bit_window_o(window),
        .word_idx_o  (word_idx)
    );

    fws_shifter #(
        .WORD_W   (WORD_W),
        .NUM_WORDS(NUM_WORDS)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .load_i    (load),
        .shift_i   (shift),
        .word_idx_i(word_idx),
        .words_i   (words_i),
        .bit_o     (shift_bit)
    );

    fws_strobe u_strobe (
        .clk     (clk),
        .window_i(window),
        .sclk_o  (sclk_o)
    );

    always_comb begin
        if (!window) begin
            sdata_o = 1'b0;
        end else if (in_flag) begin
            sdata_o = first_word;
        end else begin
            sdata_o = shift_bit;
        end
    end

    // Frame position counter used only by the checks below
    logic [FLEN_W-1:0] flen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flen_q <= '0;
        end else if (busy_o) begin
            flen_q <= flen_q + FLEN_W'(1);
        end else begin
            flen_q <= '0;
        end
    end

    assert_frame_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && flen_q == FLEN_W'(FRAME - 1)) |=> !busy_o);

    assert_no_early_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && flen_q < FLEN_W'(FRAME - 1)) |=> busy_o);

    assert_flag_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> sdata_o);

    assert_pad_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && flen_q >= FLEN_W'(NBITS)) |-> (!sdata_o && !window));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o) |-> (!sdata_o && !window));

endmodule

// File: tb/flag_word_serializer_bench.sv
`timescale 1ns/1ps
module flag_word_serializer_bench;

    localparam int W = 32;
    localparam int N = 4;
    localparam int NB = N * (W + 1);
    localparam int FR = NB + 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [N*W-1:0] words = '0;
    logic           sdata, sclk, busy;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    flag_word_serializer u_flag_word_serializer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .words_i(words),
        .sdata_o(sdata),
        .sclk_o (sclk),
        .busy_o (busy)
    );

    task automatic check(input string req, input logic act, input logic exp, input int c);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %b expected %b", req, c, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic exp_bit(input logic [N*W-1:0] ws, input int c);
        int w, p;
        if (c >= NB) return 1'b0;
        w = c / (W + 1);
        p = c % (W + 1);
        if (p == 0) return (w == 0);
        return ws[w*W + p - 1];
    endfunction

    // Launch one frame and check all of its cycles
    task automatic run_frame(input logic [N*W-1:0] ws, input int inject_at,
                             input int change_at, input logic hold);
        logic cur;
        string req;
        words = ws;
        start = 1'b1;
        tick();
        if (!hold) start = 1'b0;
        for (int c = 0; c < FR; c++) begin
            req = (c >= NB) ? "R5" : ((c % (W + 1) == 0) ? "R3" : "R4");
            check("R2 busy", busy, 1'b1, c);
            check(req, sdata, exp_bit(ws, c), c);
            check("R6 sclk low in high phase", sclk, 1'b0, c);
            cur = sdata;
            @(negedge clk);
            #1;
            check((c >= NB) ? "R5 sclk" : "R6 sclk", sclk, (c < NB), c);
            check("R6 data stable", sdata, cur, c);
            if (c == inject_at) start = 1'b1;
            if (c == change_at) words = ~ws;
            tick();
            if (c == inject_at && !hold) start = 1'b0;
        end
        check("R2 busy drops after 140", busy, 1'b0, FR);
        check("R9 idle line", sdata, 1'b0, FR);
    endtask

    task automatic t_reset();
        start = 1'b1;
        repeat (3) tick();
        check("R1 busy", busy, 1'b0, 0);
        check("R1 sdata", sdata, 1'b0, 0);
        @(negedge clk);
        #1;
        check("R1 sclk", sclk, 1'b0, 0);
        start = 1'b0;
        rst_n = 1'b1;
        tick();
        tick();
        check("R1 idle after reset", busy, 1'b0, 0);
    endtask

    task automatic t_patterns();
        run_frame({32'h8000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 32'hA5C3_0F71}, -1, -1, 1'b0);
        tick();
        run_frame({32'h1234_5678, 32'h5555_5555, 32'hAAAA_AAAA, 32'hFFFF_FFFE}, -1, -1, 1'b0);
        tick();
        run_frame({N*W{1'b0}}, -1, -1, 1'b0);
        tick();
    endtask

    task automatic t_ignore_start();
        run_frame({32'hDEAD_BEEF, 32'h0F0F_0F0F, 32'hC001_D00D, 32'h7654_3210}, 70, -1, 1'b0);
        check("R7 no restart after frame", busy, 1'b0, FR);
        tick();
        check("R7 still idle", busy, 1'b0, FR + 1);
        run_frame({32'h0000_FFFF, 32'h1111_2222, 32'h3333_4444, 32'h9999_8888}, FR - 1, -1, 1'b0);
        tick();
        check("R7 last-cycle start ignored", busy, 1'b0, FR + 1);
    endtask

    task automatic t_snapshot();
        run_frame({32'hCAFE_F00D, 32'h8421_8421, 32'h0001_0000, 32'hFEDC_BA98}, -1, 3, 1'b0);
        tick();
    endtask

    task automatic t_back_to_back();
        run_frame({32'h1357_9BDF, 32'h2468_ACE0, 32'hF0F0_F0F0, 32'h0F0F_0F0F}, -1, -1, 1'b1);
        check("R9 gap", busy, 1'b0, FR);
        run_frame({32'h1357_9BDF, 32'h2468_ACE0, 32'hF0F0_F0F0, 32'h0F0F_0F0F}, -1, -1, 1'b0);
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_patterns();
        t_ignore_start();
        t_snapshot();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule